// File: doc/BRIEF.md
# Endpoint Queue Head Overlay Engine

This block runs the queue head of a single endpoint in a USB device controller whose transfers are described by linked descriptors held in system memory. A prime request names the first descriptor. The block then reads that descriptor, word by word, into a seven-word working copy (the overlay) and records where it came from in a current-descriptor pointer. The data engine may serve the endpoint only while the overlay's token word marks the transfer as active and the configured maximum packet length is legal.

When the data engine reports the end of a transfer, the block folds the result into the overlay's token word and clears its active flag. It writes that word back to the descriptor it was copied from. It then follows the overlay's link word to the next descriptor, or stops when the link is marked as the end of the list. Separately, a receive-direction queue head latches the eight bytes of each SETUP data stage into a dedicated buffer, gives a one-cycle notice, and raises the USB interrupt pulse if the endpoint's configuration asks for it. Memory is reached through a one-word valid/ready request port with read data returned in the accepting cycle.

Top module: `qhOverlayEngine`

## Requirements
- R1: After reset, memReq, svcEnable, setupRcvd and usbInt are 0 and curDtd is 0.
- R2: A prime while idle issues exactly seven word reads at base, base+4, ..., base+24, where base is primeAddr with bits 4:0 forced to zero. curDtd then equals base, and its bits 4:0 are always zero.
- R3: If the fetched token word (overlay word 1) has its active bit (bit 7) clear, svcEnable never rises, no further memory request is made, and the block returns to idle.
- R4: With an active token and a legal packet length, svcEnable is 1 after the fetch, and no memory request is made while it is 1. ovlToken and ovlBuf0 show overlay words 1 and 2.
- R5: The maximum packet length is epCaps bits 26:16. A value above 1024 holds svcEnable at 0 and sets pktLenErr. A value of exactly 1024 is legal.
- R6: On xferDone, exactly one write goes to curDtd+4. The written data keeps bit 31 and bits 15:8 of the token, places xferRemain in bits 30:16 and xferStatus in bits 6:0, and clears bit 7.
- R7: After the write-back, if overlay word 0 has bit 0 clear, the block fetches seven words from that word with bits 4:0 zeroed and updates curDtd to that address.
- R8: If overlay word 0 has bit 0 set, the write-back is the last memory request and the endpoint goes idle.
- R9: When dirRx is 1, a setupValid cycle loads setupData into setupBuf and pulses setupRcvd for one cycle in the next cycle.
- R10: usbInt pulses together with setupRcvd only when epCaps bit 15 is set.
- R11: When dirRx is 0, setupValid has no effect: setupBuf is unchanged and neither setupRcvd nor usbInt pulses.
- R12: While memReq is 1 and memReady is 0, memReq stays 1 and memAddr, memWe and memWdata stay stable.
- R13: A prime while the block is not idle is ignored. curDtd does not change and no memory request starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prime | input | 1 | Start pulse naming the first descriptor |
| primeAddr | input | 32 | Address of the first descriptor |
| epCaps | input | 32 | Endpoint capabilities: max packet 26:16, setup interrupt enable 15 |
| dirRx | input | 1 | 1 for the receive-direction queue head |
| xferDone | input | 1 | Data engine reports the end of the current transfer |
| xferStatus | input | 7 | Result status folded into token bits 6:0 |
| xferRemain | input | 15 | Remaining byte count folded into token bits 30:16 |
| setupValid | input | 1 | A SETUP data stage is present on setupData |
| setupData | input | 64 | Eight setup bytes |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 for a write request |
| memAddr | output | 32 | Word address (byte addressed) |
| memWdata | output | 32 | Write data |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRdata | input | 32 | Read data, valid with memReady |
| svcEnable | output | 1 | Endpoint may be served by the data engine |
| pktLenErr | output | 1 | Configured maximum packet length is above 1024 |
| curDtd | output | 32 | Current descriptor pointer |
| ovlToken | output | 32 | Overlay token word |
| ovlBuf0 | output | 32 | Overlay first buffer pointer |
| setupBuf | output | 64 | Captured setup bytes |
| setupRcvd | output | 1 | One-cycle notice of a captured setup |
| usbInt | output | 1 | USB interrupt pulse on setup |

## Verification
The assertions assume the data engine asserts xferDone only while svcEnable or an active overlay is present. They also assume the memory answers every request eventually and returns read data in the same cycle as memReady. The bench's memory model alternates a one-cycle stall with immediate acceptance, so each request is seen both waiting and accepted. The bench raises xferDone only after it has seen the block reach its serving state, and it changes dirRx and epCaps only between scenarios, never during a setup pulse.

// File: rtl/qhPkg.sv
package qhPkg;
  localparam int WORD_W     = 32;
  localparam int OVL_WORDS  = 7;
  localparam int LINK_IDX   = 0;
  localparam int TOKEN_IDX  = 1;
  localparam int BUF0_IDX   = 2;
  localparam int ACTIVE_BIT = 7;
  localparam int IDX_W      = $clog2(OVL_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ACTIVE, ST_WRITEBACK, ST_ADVANCE
  } qhState_t;

  typedef struct packed {
    logic startFetch;
    logic fromLink;
    logic capWord;
    logic mergeDone;
    logic wbSel;
  } qhStrobes_t;
endpackage

// File: rtl/qhDatapath.sv
module qhDatapath
  import qhPkg::*;
#(
  parameter int MAX_PKT_LIMIT = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  qhStrobes_t         stb,
  input  logic [WORD_W-1:0]  primeAddr,
  input  logic [WORD_W-1:0]  epCaps,
  input  logic               dirRx,
  input  logic [6:0]         xferStatus,
  input  logic [14:0]        xferRemain,
  input  logic               setupValid,
  input  logic [63:0]        setupData,
  input  logic [WORD_W-1:0]  memRdata,
  output logic [WORD_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  memWdata,
  output logic               lastWord,
  output logic               tokenActive,
  output logic               linkTerm,
  output logic               pktLenOk,
  output logic [WORD_W-1:0]  curDtd,
  output logic [WORD_W-1:0]  ovlToken,
  output logic [WORD_W-1:0]  ovlBuf0,
  output logic [63:0]        setupBuf,
  output logic               setupRcvd,
  output logic               usbInt
);
  localparam int PKT_LSB = 16;
  localparam int PKT_W   = 11;
  localparam int IOS_BIT = 15;

  logic [WORD_W-1:0] ovl [OVL_WORDS];
  logic [IDX_W-1:0]  wordIdx;
  logic [WORD_W-1:0] nextBase;
  logic [PKT_W-1:0]  maxPkt;
  logic              takeSetup;

  assign nextBase = stb.fromLink ? {ovl[LINK_IDX][WORD_W-1:5], 5'b0}
                                 : {primeAddr[WORD_W-1:5], 5'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDtd  <= '0;
      wordIdx <= '0;
      for (int i = 0; i < OVL_WORDS; i++) ovl[i] <= '0;
    end else begin
      if (stb.startFetch) begin
        curDtd  <= nextBase;
        wordIdx <= '0;
      end else if (stb.capWord) begin
        ovl[wordIdx] <= memRdata;
        wordIdx      <= wordIdx + 1'b1;
      end
      if (stb.mergeDone) begin
        ovl[TOKEN_IDX] <= {ovl[TOKEN_IDX][31], xferRemain,
                           ovl[TOKEN_IDX][15:8], 1'b0, xferStatus};
      end
    end
  end

  assign memAddr  = stb.wbSel ? curDtd + WORD_W'(4 * TOKEN_IDX)
                              : curDtd + (WORD_W'(wordIdx) << 2);
  assign memWdata = ovl[TOKEN_IDX];
  assign lastWord = (wordIdx == IDX_W'(OVL_WORDS - 1));
  assign tokenActive = ovl[TOKEN_IDX][ACTIVE_BIT];
  assign linkTerm    = ovl[LINK_IDX][0];
  assign ovlToken    = ovl[TOKEN_IDX];
  assign ovlBuf0     = ovl[BUF0_IDX];

  assign maxPkt   = epCaps[PKT_LSB +: PKT_W];
  assign pktLenOk = (32'(maxPkt) <= 32'(MAX_PKT_LIMIT));

  assign takeSetup = setupValid && dirRx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupBuf  <= '0;
      setupRcvd <= 1'b0;
      usbInt    <= 1'b0;
    end else begin
      setupRcvd <= takeSetup;
      usbInt    <= takeSetup && epCaps[IOS_BIT];
      if (takeSetup) setupBuf <= setupData;
    end
  end
endmodule

// File: rtl/qhControl.sv
module qhControl
  import qhPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       prime,
  input  logic       xferDone,
  input  logic       memReady,
  input  logic       lastWord,
  input  logic       tokenActive,
  input  logic       linkTerm,
  input  logic       pktLenOk,
  output qhStrobes_t stb,
  output logic       memReq,
  output logic       memWe,
  output logic       svcEnable
);
  qhState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (prime) begin
          stb.startFetch = 1'b1;
          nextState      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memReady) begin
          stb.capWord = 1'b1;
          if (lastWord) nextState = tokenActive ? ST_ACTIVE : ST_IDLE;
        end
      end
      ST_ACTIVE: begin
        if (xferDone) begin
          stb.mergeDone = 1'b1;
          nextState     = ST_WRITEBACK;
        end
      end
      ST_WRITEBACK: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        stb.wbSel = 1'b1;
        if (memReady) nextState = ST_ADVANCE;
      end
      ST_ADVANCE: begin
        if (linkTerm) nextState = ST_IDLE;
        else begin
          stb.startFetch = 1'b1;
          stb.fromLink   = 1'b1;
          nextState      = ST_FETCH;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign svcEnable = (state == ST_ACTIVE) && tokenActive && pktLenOk;
endmodule

// File: rtl/qhOverlayEngine.sv
module qhOverlayEngine
  import qhPkg::*;
#(
  parameter int MAX_PKT_LIMIT = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        prime,
  input  logic [31:0] primeAddr,
  input  logic [31:0] epCaps,
  input  logic        dirRx,
  input  logic        xferDone,
  input  logic [6:0]  xferStatus,
  input  logic [14:0] xferRemain,
  input  logic        setupValid,
  input  logic [63:0] setupData,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memReady,
  input  logic [31:0] memRdata,
  output logic        svcEnable,
  output logic        pktLenErr,
  output logic [31:0] curDtd,
  output logic [31:0] ovlToken,
  output logic [31:0] ovlBuf0,
  output logic [63:0] setupBuf,
  output logic        setupRcvd,
  output logic        usbInt
);
  qhStrobes_t stb;
  logic lastWord, tokenActive, linkTerm, pktLenOk;

  qhControl uCtrl (
    .clk(clk), .rstN(rstN), .prime(prime), .xferDone(xferDone),
    .memReady(memReady), .lastWord(lastWord), .tokenActive(tokenActive),
    .linkTerm(linkTerm), .pktLenOk(pktLenOk), .stb(stb),
    .memReq(memReq), .memWe(memWe), .svcEnable(svcEnable)
  );

  qhDatapath #(.MAX_PKT_LIMIT(MAX_PKT_LIMIT)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .primeAddr(primeAddr),
    .epCaps(epCaps), .dirRx(dirRx), .xferStatus(xferStatus),
    .xferRemain(xferRemain), .setupValid(setupValid), .setupData(setupData),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .lastWord(lastWord), .tokenActive(tokenActive), .linkTerm(linkTerm),
    .pktLenOk(pktLenOk), .curDtd(curDtd), .ovlToken(ovlToken),
    .ovlBuf0(ovlBuf0), .setupBuf(setupBuf), .setupRcvd(setupRcvd),
    .usbInt(usbInt)
  );

  assign pktLenErr = !pktLenOk;
endmodule

// File: rtl/qhOverlayChecker.sv
module qhOverlayChecker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] epCaps,
  input logic        dirRx,
  input logic        setupValid,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata,
  input logic        memReady,
  input logic        svcEnable,
  input logic [31:0] curDtd,
  input logic        setupRcvd,
  input logic        usbInt
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !memReq && !setupRcvd && !usbInt);

  p_dtd_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    curDtd[4:0] == 5'd0);

  p_fetch_in_dtd_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> (memAddr[1:0] == 2'd0) && (memAddr[4:0] <= 5'd24));

  p_no_req_while_svc_r4: assert property (@(posedge clk) disable iff (!rstN)
    svcEnable |-> !memReq);

  p_len_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    svcEnable |-> (epCaps[26:16] <= 11'd1024));

  p_wb_inactive_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !memWdata[7] && (memAddr[4:0] == 5'd4));

  p_setup_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    setupRcvd |-> $past(setupValid) && $past(dirRx));

  p_int_with_setup_r10: assert property (@(posedge clk) disable iff (!rstN)
    usbInt |-> setupRcvd);

  p_tx_ignores_r11: assert property (@(posedge clk) disable iff (!rstN)
    !dirRx |=> !usbInt || $past(setupValid && dirRx));

  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe)
                            && $stable(memWdata));
endmodule

bind qhOverlayEngine qhOverlayChecker uChk (
  .clk(clk), .rstN(rstN), .epCaps(epCaps), .dirRx(dirRx),
  .setupValid(setupValid), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
  .svcEnable(svcEnable), .curDtd(curDtd), .setupRcvd(setupRcvd),
  .usbInt(usbInt)
);

// File: tb/qhOverlayEngine_test.sv
`timescale 1ns/1ps
module qhOverlayEngine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        prime = 1'b0;
  logic [31:0] primeAddr = '0;
  logic [31:0] epCaps = '0;
  logic        dirRx = 1'b0;
  logic        xferDone = 1'b0;
  logic [6:0]  xferStatus = '0;
  logic [14:0] xferRemain = '0;
  logic        setupValid = 1'b0;
  logic [63:0] setupData = '0;
  logic        memReq, memWe, memReady;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        svcEnable, pktLenErr, setupRcvd, usbInt;
  logic [31:0] curDtd, ovlToken, ovlBuf0;
  logic [63:0] setupBuf;

  always #4 clk = ~clk;

  qhOverlayEngine uut (
    .clk(clk), .rstN(rstN), .prime(prime), .primeAddr(primeAddr),
    .epCaps(epCaps), .dirRx(dirRx), .xferDone(xferDone),
    .xferStatus(xferStatus), .xferRemain(xferRemain),
    .setupValid(setupValid), .setupData(setupData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .svcEnable(svcEnable),
    .pktLenErr(pktLenErr), .curDtd(curDtd), .ovlToken(ovlToken),
    .ovlBuf0(ovlBuf0), .setupBuf(setupBuf), .setupRcvd(setupRcvd),
    .usbInt(usbInt)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [256];
  int          rdCount, wrCount, holdErr;
  logic [31:0] rdLog [64];
  logic [31:0] lastWrAddr, lastWrData;
  logic        svcSeen;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: alternate one stall cycle with immediate acceptance
  initial begin
    logic stallTog;
    logic holdPend;
    logic [31:0] hAddr, hWd;
    logic hWe;
    stallTog = 1'b0; holdPend = 1'b0;
    hAddr = '0; hWd = '0; hWe = 1'b0;
    memReady = 1'b0; memRdata = '0;
    forever begin
      @(negedge clk);
      if (svcEnable) svcSeen = 1'b1;
      if (holdPend && (!memReq || memAddr !== hAddr || memWe !== hWe || memWdata !== hWd))
        holdErr++;
      holdPend = 1'b0;
      if (memReq) begin
        if (stallTog) begin
          memReady = 1'b0;
          holdPend = 1'b1; hAddr = memAddr; hWe = memWe; hWd = memWdata;
        end else begin
          memReady = 1'b1;
          if (memWe) begin
            mem[memAddr[9:2]] = memWdata;
            wrCount++; lastWrAddr = memAddr; lastWrData = memWdata;
          end else begin
            memRdata = mem[memAddr[9:2]];
            if (rdCount < 64) rdLog[rdCount] = memAddr;
            rdCount++;
          end
        end
        stallTog = ~stallTog;
      end else memReady = 1'b0;
    end
  end

  task automatic clearLog();
    rdCount = 0; wrCount = 0; svcSeen = 1'b0;
    lastWrAddr = '0; lastWrData = '0;
  endtask

  task automatic putDtd(input logic [31:0] base, input logic [31:0] link,
                        input logic [31:0] tok, input logic [31:0] buf0);
    mem[base[9:2]]     = link;
    mem[base[9:2] + 1] = tok;
    mem[base[9:2] + 2] = buf0;
    for (int i = 3; i < 7; i++) mem[base[9:2] + i] = base + 32'(i);
  endtask

  task automatic doPrime(input logic [31:0] a);
    @(negedge clk); prime = 1'b1; primeAddr = a;
    @(negedge clk); prime = 1'b0;
  endtask

  task automatic waitSvc();
    for (int i = 0; i < 100 && !svcEnable; i++) @(negedge clk);
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishXfer(input logic [6:0] st, input logic [14:0] rem);
    @(negedge clk); xferDone = 1'b1; xferStatus = st; xferRemain = rem;
    @(negedge clk); xferDone = 1'b0;
  endtask

  task automatic checkReads(input string req, input logic [31:0] base, input int from);
    for (int i = 0; i < 7; i++) chk(req, 64'(rdLog[from + i]), 64'(base + 32'(4 * i)));
  endtask

  task automatic t_reset();
    chk("R1 memReq", 64'(memReq), 64'd0);
    chk("R1 svcEnable", 64'(svcEnable), 64'd0);
    chk("R1 curDtd", 64'(curDtd), 64'd0);
    chk("R1 setupRcvd", 64'(setupRcvd), 64'd0);
    chk("R1 usbInt", 64'(usbInt), 64'd0);
  endtask

  task automatic t_single();
    logic [31:0] tok;
    tok = 32'h8040_5A80;
    putDtd(32'h100, 32'h1, tok, 32'hCAFE_0000);
    epCaps = 32'd512 << 16;
    clearLog();
    doPrime(32'h10B);
    waitSvc();
    chk("R2 read count", 64'(rdCount), 64'd7);
    checkReads("R2 read addr", 32'h100, 0);
    chk("R2 curDtd", 64'(curDtd), 64'h100);
    chk("R4 svcEnable", 64'(svcEnable), 64'd1);
    chk("R4 ovlToken", 64'(ovlToken), 64'(tok));
    chk("R4 ovlBuf0", 64'(ovlBuf0), 64'hCAFE_0000);
    // R13: prime while busy
    doPrime(32'h300);
    idleCycles(5);
    chk("R13 curDtd", 64'(curDtd), 64'h100);
    chk("R13 reads", 64'(rdCount), 64'd7);
    finishXfer(7'h05, 15'h0010);
    idleCycles(20);
    chk("R6 write count", 64'(wrCount), 64'd1);
    chk("R6 write addr", 64'(lastWrAddr), 64'h104);
    chk("R6 write data", 64'(lastWrData),
        64'({tok[31], 15'h0010, tok[15:8], 1'b0, 7'h05}));
    chk("R8 no reads after", 64'(rdCount), 64'd7);
    chk("R8 svcEnable", 64'(svcEnable), 64'd0);
    chk("R8 memReq", 64'(memReq), 64'd0);
  endtask

  task automatic t_chain();
    putDtd(32'h200, 32'h240, 32'h0001_0080, 32'h1111_0000);
    putDtd(32'h240, 32'h1,   32'h0002_0081, 32'h2222_0000);
    epCaps = 32'd64 << 16;
    clearLog();
    doPrime(32'h200);
    waitSvc();
    finishXfer(7'h00, 15'h0000);
    for (int i = 0; i < 100 && !(svcEnable && curDtd == 32'h240); i++) @(negedge clk);
    chk("R7 curDtd", 64'(curDtd), 64'h240);
    chk("R7 read count", 64'(rdCount), 64'd14);
    checkReads("R7 read addr", 32'h240, 7);
    chk("R7 ovlToken", 64'(ovlToken), 64'h0002_0081);
    chk("R7 first wb addr", 64'(lastWrAddr), 64'h204);
    finishXfer(7'h03, 15'h0005);
    idleCycles(20);
    chk("R8 chain end writes", 64'(wrCount), 64'd2);
    chk("R6 chain wb data", 64'(lastWrData), 64'h0005_0003);
    chk("R8 chain end reads", 64'(rdCount), 64'd14);
  endtask

  task automatic t_inactive();
    putDtd(32'h300, 32'h340, 32'h0010_0000, 32'h3333_0000);
    putDtd(32'h340, 32'h1, 32'h0000_0080, 32'h0);
    epCaps = 32'd64 << 16;
    clearLog();
    doPrime(32'h300);
    idleCycles(40);
    chk("R3 reads", 64'(rdCount), 64'd7);
    chk("R3 svc never", 64'(svcSeen), 64'd0);
    chk("R3 memReq", 64'(memReq), 64'd0);
    chk("R3 writes", 64'(wrCount), 64'd0);
  endtask

  task automatic t_pktlen();
    putDtd(32'h380, 32'h1, 32'h0000_0080, 32'h0);
    epCaps = 32'd1025 << 16;
    clearLog();
    doPrime(32'h380);
    idleCycles(40);
    chk("R5 len 1025 svc", 64'(svcSeen), 64'd0);
    chk("R5 len 1025 err", 64'(pktLenErr), 64'd1);
    epCaps = 32'd1024 << 16;
    @(negedge clk);
    chk("R5 len 1024 svc", 64'(svcEnable), 64'd1);
    chk("R5 len 1024 err", 64'(pktLenErr), 64'd0);
    finishXfer(7'h00, 15'h0);
    idleCycles(20);
  endtask

  task automatic t_setup();
    logic [63:0] d1, d2, d3;
    d1 = 64'h0102_0304_0506_0708;
    d2 = 64'hA1A2_A3A4_A5A6_A7A8;
    d3 = 64'hDEAD_BEEF_0000_1111;
    dirRx = 1'b1; epCaps = 32'd64 << 16;
    @(negedge clk); setupValid = 1'b1; setupData = d1;
    @(negedge clk); setupValid = 1'b0;
    chk("R9 setupRcvd", 64'(setupRcvd), 64'd1);
    chk("R9 setupBuf", setupBuf, d1);
    chk("R10 no int without enable", 64'(usbInt), 64'd0);
    @(negedge clk);
    chk("R9 pulse one cycle", 64'(setupRcvd), 64'd0);
    epCaps = (32'd64 << 16) | 32'h8000;
    @(negedge clk); setupValid = 1'b1; setupData = d2;
    @(negedge clk); setupValid = 1'b0;
    chk("R10 usbInt", 64'(usbInt), 64'd1);
    chk("R9 overwrite", setupBuf, d2);
    @(negedge clk);
    chk("R10 int one cycle", 64'(usbInt), 64'd0);
    dirRx = 1'b0;
    @(negedge clk); setupValid = 1'b1; setupData = d3;
    @(negedge clk); setupValid = 1'b0;
    chk("R11 no pulse", 64'(setupRcvd), 64'd0);
    chk("R11 no int", 64'(usbInt), 64'd0);
    chk("R11 buffer kept", setupBuf, d2);
  endtask

  initial begin
    holdErr = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    clearLog();
    idleCycles(4);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_inactive();
    t_pktlen();
    t_setup();
    chk("R12 request held while stalled", 64'(holdErr), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule